// File: doc/BRIEF.md
# PCI Read Command Burst Mapper

This block sits between the target side of a PCI interface and an internal word-wide local bus. When a PCI master issues a memory read, the mapper takes the command code and start address and turns them into one local bus read request. It decides whether the request is a single word or a word burst. It also fills the request's byte-enable lines, which double as a burst-length field.

There are three read flavours. A plain read asks for one word. A line read asks for the words from the start address up to the next 32-byte boundary, and the count of those words goes on the byte-enable lines. A start on the final word of a block falls back to a single word. A multiple read asks for an open-ended burst, marked by an all-zero field. The mapper never ends a burst itself; the local bus target does that.

The request is registered one cycle after the strobe. It then holds steady until the local bus acknowledges the address. Block size, word size and address width are parameters.

Top module: `pcirm_top`

## Requirements
- R1: While reset is held and after it is released, `lb_req`, `lb_burst`, `lb_open`, `lb_be` and `lb_addr` are all zero until a read command is accepted.
- R2: A strobe with code 4'b0110 (plain read) gives, one cycle later, `lb_req`=1, `lb_burst`=0, `lb_open`=0 and `lb_be`=all ones.
- R3: A strobe with code 4'b1110 (line read) whose word index addr[4:2] is w, for w from 0 to 6, gives one cycle later `lb_req`=1, `lb_burst`=1, `lb_open`=0 and `lb_be` equal to the binary count 8-w.
- R4: A line read whose word index addr[4:2] is 7 gives a single-word request, encoded exactly as in R2.
- R5: A strobe with code 4'b1100 (multiple read) gives one cycle later `lb_req`=1, `lb_burst`=1, `lb_open`=1 and `lb_be`=4'b0000, whatever the address.
- R6: A strobe with any other code raises no request: `lb_req` stays 0.
- R7: A raised request keeps all its outputs unchanged until `lb_addr_ack` is sampled high, and `lb_req` is 0 in the cycle after that sample.
- R8: A strobe that arrives while `lb_req` is 1 is ignored, even in the same cycle as the acknowledge. The outputs stay unchanged and no request follows it.
- R9: `lb_addr` equals the start address with its two low (byte-within-word) bits cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe: command and address are valid this cycle |
| cmd_code | input | 4 | PCI command code |
| cmd_addr | input | ADDR_W (32) | Start byte address of the read |
| lb_addr_ack | input | 1 | Local bus address acknowledge for the pending request |
| lb_req | output | 1 | Local bus read request pending |
| lb_addr | output | ADDR_W (32) | Word-aligned request address |
| lb_burst | output | 1 | 1 = word burst, 0 = single word |
| lb_be | output | WORD_BYTES (4) | Byte enables, or burst length on a line read |
| lb_open | output | 1 | Burst has no set length (multiple read) |

## Verification
The assertions assume that `lb_addr_ack` is high only while `lb_req` is high, and that the command inputs settle before the clock edge at which the strobe is sampled. The bench keeps to these rules. It raises the acknowledge only after it has seen a pending request, and it changes every input at the falling edge. Random codes are drawn mostly from the three read codes and partly from the other thirteen, with random addresses and random acknowledge delays. Directed cases cover each word index of a line read and strobes that arrive while a request is pending, including one that coincides with the acknowledge.

// File: rtl/pcirm_pkg.sv
package pcirm_pkg;

   localparam logic [3:0] CMD_RD_WORD  = 4'b0110;
   localparam logic [3:0] CMD_RD_LINE  = 4'b1110;
   localparam logic [3:0] CMD_RD_MULTI = 4'b1100;

   typedef enum logic [1:0] {
      RK_NONE   = 2'd0,
      RK_SINGLE = 2'd1,
      RK_LINE   = 2'd2,
      RK_MULTI  = 2'd3
   } rd_kind_e;

endpackage

// File: rtl/pcirm_decode.sv
module pcirm_decode
   import pcirm_pkg::*;
(
   input  logic [3:0] code,
   output rd_kind_e   kind
);

   always_comb begin
      case (code)
         CMD_RD_WORD:  kind = RK_SINGLE;
         CMD_RD_LINE:  kind = RK_LINE;
         CMD_RD_MULTI: kind = RK_MULTI;
         default:      kind = RK_NONE;
      endcase
   end

endmodule

// File: rtl/pcirm_len.sv
module pcirm_len #(
   parameter int WORDS_PER_BLK = 8,
   parameter int WIDX_W        = 3,
   parameter int LEN_W         = 4
) (
   input  logic [WIDX_W-1:0] word_idx,
   output logic [LEN_W-1:0]  len,
   output logic              last_word
);

   generate
      if (WORDS_PER_BLK == 1) begin : g_one
         logic unused_idx;
         assign unused_idx = ^word_idx;
         assign len        = LEN_W'(1);
         assign last_word  = 1'b1;
      end else begin : g_many
         assign len       = LEN_W'(WORDS_PER_BLK) - LEN_W'(word_idx);
         assign last_word = (word_idx == WIDX_W'(WORDS_PER_BLK - 1));
      end
   endgenerate

   always_comb begin
      if (!last_word) begin
         a_len_min_r3: assert (len >= LEN_W'(2))
            else $error("line length below two words");
      end
   end

endmodule

// File: rtl/pcirm_hold.sv
module pcirm_hold #(
   parameter int ADDR_W = 32,
   parameter int BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              burst_d,
   input  logic [BE_W-1:0]   be_d,
   input  logic              open_d,
   input  logic              ack,
   output logic              req_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              burst_q,
   output logic [BE_W-1:0]   be_q,
   output logic              open_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         addr_q  <= '0;
         burst_q <= 1'b0;
         be_q    <= '0;
         open_q  <= 1'b0;
      end else if (load) begin
         req_q   <= 1'b1;
         addr_q  <= addr_d;
         burst_q <= burst_d;
         be_q    <= be_d;
         open_q  <= open_d;
      end else if (req_q && ack) begin
         req_q   <= 1'b0;
      end
   end

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_q && !ack |=> req_q && $stable(addr_q) && $stable(be_q)
                        && $stable(burst_q) && $stable(open_q))
      else $error("request changed before acknowledge");

   p_drop_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_q && ack |=> !req_q)
      else $error("request still pending after acknowledge");

endmodule

// File: rtl/pcirm_top.sv
module pcirm_top
   import pcirm_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_BYTES  = 4,
   parameter int BLOCK_BYTES = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [3:0]            cmd_code,
   input  logic [ADDR_W-1:0]     cmd_addr,
   input  logic                  lb_addr_ack,
   output logic                  lb_req,
   output logic [ADDR_W-1:0]     lb_addr,
   output logic                  lb_burst,
   output logic [WORD_BYTES-1:0] lb_be,
   output logic                  lb_open
);

   localparam int WORD_LSB      = $clog2(WORD_BYTES);
   localparam int BLK_LSB       = $clog2(BLOCK_BYTES);
   localparam int WORDS_PER_BLK = BLOCK_BYTES / WORD_BYTES;
   localparam int WIDX_W        = (WORDS_PER_BLK > 1) ? $clog2(WORDS_PER_BLK) : 1;
   localparam int BE_W          = WORD_BYTES;

   generate
      if ((1 << WORD_LSB) != WORD_BYTES) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if ((1 << BLK_LSB) != BLOCK_BYTES || BLOCK_BYTES < WORD_BYTES) begin : g_bad_blk
         $error("BLOCK_BYTES must be a power of two no smaller than a word");
      end
      if (WORDS_PER_BLK >= (1 << BE_W)) begin : g_bad_len
         $error("burst length does not fit in the byte-enable field");
      end
      if (ADDR_W <= BLK_LSB) begin : g_bad_addr
         $error("ADDR_W too small for the block size");
      end
   endgenerate

   rd_kind_e          kind;
   logic [WIDX_W-1:0] word_idx;
   logic [BE_W-1:0]   line_len;
   logic              line_last;
   logic              nx_burst;
   logic              nx_open;
   logic [BE_W-1:0]   nx_be;
   logic [ADDR_W-1:0] nx_addr;
   logic              load;

   pcirm_decode u_dec (
      .code (cmd_code),
      .kind (kind)
   );

   generate
      if (WORDS_PER_BLK > 1) begin : g_idx
         assign word_idx = cmd_addr[BLK_LSB-1:WORD_LSB];
      end else begin : g_idx1
         assign word_idx = '0;
      end
   endgenerate

   pcirm_len #(
      .WORDS_PER_BLK (WORDS_PER_BLK),
      .WIDX_W        (WIDX_W),
      .LEN_W         (BE_W)
   ) u_len (
      .word_idx  (word_idx),
      .len       (line_len),
      .last_word (line_last)
   );

   always_comb begin
      nx_burst = 1'b0;
      nx_open  = 1'b0;
      nx_be    = '1;
      case (kind)
         RK_LINE: begin
            if (!line_last) begin
               nx_burst = 1'b1;
               nx_be    = line_len;
            end
         end
         RK_MULTI: begin
            nx_burst = 1'b1;
            nx_open  = 1'b1;
            nx_be    = '0;
         end
         default: ;
      endcase
   end

   assign nx_addr = cmd_addr & ~ADDR_W'(WORD_BYTES - 1);
   assign load    = cmd_valid && !lb_req && (kind != RK_NONE);

   pcirm_hold #(
      .ADDR_W (ADDR_W),
      .BE_W   (BE_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .addr_d  (nx_addr),
      .burst_d (nx_burst),
      .be_d    (nx_be),
      .open_d  (nx_open),
      .ack     (lb_addr_ack),
      .req_q   (lb_req),
      .addr_q  (lb_addr),
      .burst_q (lb_burst),
      .be_q    (lb_be),
      .open_q  (lb_open)
   );

   p_open_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lb_req && lb_open |-> lb_burst && (lb_be == '0))
      else $error("open burst without all-zero field");

   p_single_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lb_req && !lb_burst |-> (lb_be == '1) && !lb_open)
      else $error("single word without full byte enables");

   p_line_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lb_req && lb_burst && !lb_open |->
         (lb_be >= BE_W'(2)) && (lb_be <= BE_W'(WORDS_PER_BLK)))
      else $error("line length out of range");

   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lb_req && cmd_valid |=> $stable(lb_addr) && $stable(lb_be)
                              && $stable(lb_burst) && $stable(lb_open))
      else $error("strobe while pending changed the request");

   p_no_req_bad_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lb_req && !(cmd_valid && kind != RK_NONE) |=> !lb_req)
      else $error("request raised without a read command");

   p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lb_req |-> (lb_addr[WORD_LSB-1:0] == '0))
      else $error("request address not word aligned");

endmodule

// File: tb/sim_pcirm_top.sv
module sim_pcirm_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic [3:0]  cmd_code;
   logic [31:0] cmd_addr;
   logic        lb_addr_ack;
   logic        lb_req;
   logic [31:0] lb_addr;
   logic        lb_burst;
   logic [3:0]  lb_be;
   logic        lb_open;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   pcirm_top u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_code    (cmd_code),
      .cmd_addr    (cmd_addr),
      .lb_addr_ack (lb_addr_ack),
      .lb_req      (lb_req),
      .lb_addr     (lb_addr),
      .lb_burst    (lb_burst),
      .lb_be       (lb_be),
      .lb_open     (lb_open)
   );

   // packed view: {req, burst, open, be[3:0], addr[31:0]}
   function automatic logic [38:0] outs();
      return {lb_req, lb_burst, lb_open, lb_be, lb_addr};
   endfunction

   function automatic logic [38:0] expect_of(logic [3:0] code, logic [31:0] addr);
      logic [31:0] a;
      a = {addr[31:2], 2'b00};
      case (code)
         4'b0110: return {1'b1, 1'b0, 1'b0, 4'b1111, a};
         4'b1110: begin
            if (addr[4:2] == 3'd7) return {1'b1, 1'b0, 1'b0, 4'b1111, a};
            return {1'b1, 1'b1, 1'b0, 4'(4'd8 - {1'b0, addr[4:2]}), a};
         end
         4'b1100: return {1'b1, 1'b1, 1'b1, 4'b0000, a};
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] code, logic [31:0] addr);
      case (code)
         4'b0110: return "R2/R9";
         4'b1110: return (addr[4:2] == 3'd7) ? "R4/R9" : "R3/R9";
         4'b1100: return "R5/R9";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [38:0] act, logic [38:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(logic [3:0] code, logic [31:0] addr, int wait_n);
      logic [38:0] e;
      e = expect_of(code, addr);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = code;
      cmd_addr  = addr;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = $urandom_range(0, 15);
      cmd_addr  = $urandom;
      if (!e[38]) begin
         check("R6", {38'd0, lb_req}, 39'd0);
         return;
      end
      check(tag_of(code, addr), outs(), e);
      for (int i = 0; i < wait_n; i++) begin
         @(negedge clk);
         check("R7 hold", outs(), e);
      end
      lb_addr_ack = 1'b1;
      @(negedge clk);
      lb_addr_ack = 1'b0;
      check("R7 drop", {38'd0, lb_req}, 39'd0);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [38:0] e;
      void'($urandom(32'h5eed_0417));
      rst_n       = 1'b0;
      cmd_valid   = 1'b0;
      cmd_code    = 4'b0110;
      cmd_addr    = 32'hFFFF_FFFF;
      lb_addr_ack = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", outs(), 39'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", outs(), 39'd0);

      // directed: every word index of a line read
      for (int w = 0; w < 8; w++) run(4'b1110, 32'h0000_1000 + 32'(w * 4) + 32'(w % 4), w % 3);
      run(4'b0110, 32'h8000_0013, 0);
      run(4'b1100, 32'h0000_001C, 1);
      run(4'b1100, 32'h1234_5671, 0);
      run(4'b0111, 32'h0000_0000, 0);
      run(4'b1111, 32'h0000_0004, 0);

      // R8: strobe while pending, then strobe coinciding with acknowledge
      e = expect_of(4'b1110, 32'h0000_2008);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 4'b1110; cmd_addr = 32'h0000_2008;
      @(negedge clk);
      cmd_code = 4'b1100; cmd_addr = 32'hABCD_0000;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R8 busy strobe", outs(), e);
      cmd_valid = 1'b1; cmd_code = 4'b0110; lb_addr_ack = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; lb_addr_ack = 1'b0;
      check("R8 strobe at ack", {38'd0, lb_req}, 39'd0);
      @(negedge clk);
      check("R8 no late request", {38'd0, lb_req}, 39'd0);

      // random traffic
      for (int k = 0; k < 400; k++) begin
         logic [3:0] c;
         int sel;
         sel = $urandom_range(0, 9);
         case (sel)
            0, 1, 2: c = 4'b0110;
            3, 4, 5: c = 4'b1110;
            6, 7:    c = 4'b1100;
            default: c = 4'($urandom_range(0, 15));
         endcase
         run(c, $urandom, $urandom_range(0, 3));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule